// File: doc/BRIEF.md
# Operand Bypass and Load-Use Unit

This block is the forwarding and interlock control for a five-stage in-order pipeline. For each of the two ALU operands entering the EX stage, it chooses one of three sources. The first is the value latched in the ID/EX register. The second is the ALU result held in the MEM stage. The third is the final write-back value in the WB stage, which may be ALU data or load data. The choice follows which older instruction writes the register the operand names. The choice is purely combinational from the current stage contents, so it adds no cycle of latency.

The block also bypasses the register file. When the ID stage reads a register that WB writes in the same cycle, the write-back value replaces the raw read data. This means the register file itself needs no write-before-read timing.

A load leaves its data ready only in WB. An instruction in ID that reads a load's destination while that load is in EX therefore cannot go ahead. For one cycle the unit asserts a hold (PC and IF/ID keep their values) and a bubble (ID/EX takes a nop). A two-state machine guards this interlock. In `LU_RUN` the hazard is evaluated. The transition `RUN_TO_HOLD` fires when a load-use hazard is seen and the stall is raised. The transition `RUN_STAY` applies otherwise. In `LU_HOLD` the stall is held low, and the transition `HOLD_TO_RUN` always returns to `LU_RUN`. After the hold, the loaded value reaches EX through the WB path. Register index 0 is hard-wired zero. It is never forwarded and never causes a stall.

Top module: `opbypass_unit`

## Requirements
- R1: When the MEM instruction writes (mem_wen=1), is not a load, has a nonzero destination and that destination equals an EX source index, that EX operand output equals mem_alu_res in the same cycle.
- R2: When the MEM stage does not qualify under R1 for an operand, and the WB stage writes (wb_wen=1) a nonzero destination equal to that EX source index, the EX operand output equals wb_data.
- R3: When both MEM (qualifying under R1) and WB match the same EX source, the MEM value is chosen.
- R4: A MEM-stage load (mem_is_load=1) is never forwarded. The operand falls back to the WB match if there is one, otherwise to the ID/EX value.
- R5: Source or destination index 0 never forwards in EX or ID and never raises the stall.
- R6: When WB writes a nonzero destination equal to an ID source index, that ID read output equals wb_data; otherwise it equals the raw register-file data for that port.
- R7: In state LU_RUN, stall_o and bubble_o are both 1 in the same cycle when EX holds a writing load (ex_is_load=1, ex_wen=1) with nonzero ex_rd equal to id_rs_a or id_rs_b.
- R8: A stall lasts exactly one cycle. In the cycle after a stall the unit is in LU_HOLD and keeps stall_o low even if the hazard inputs persist. The cycle after that it is back in LU_RUN.
- R9: A stage whose write flag is 0 never forwards and never causes a stall, even when its indices match.
- R10: After reset the machine is in LU_RUN. With all inputs zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs_a | input | AW | ID-stage first source index |
| id_rs_b | input | AW | ID-stage second source index |
| id_rf_rd_a | input | XLEN | Raw register-file data, first port |
| id_rf_rd_b | input | XLEN | Raw register-file data, second port |
| ex_rs_a | input | AW | EX-stage first source index |
| ex_rs_b | input | AW | EX-stage second source index |
| ex_opnd_a | input | XLEN | ID/EX latched first operand |
| ex_opnd_b | input | XLEN | ID/EX latched second operand |
| ex_rd | input | AW | EX-stage destination index |
| ex_wen | input | 1 | EX instruction writes a register |
| ex_is_load | input | 1 | EX instruction is a load |
| mem_rd | input | AW | MEM-stage destination index |
| mem_wen | input | 1 | MEM instruction writes a register |
| mem_is_load | input | 1 | MEM instruction is a load |
| mem_alu_res | input | XLEN | ALU result held in MEM |
| wb_rd | input | AW | WB-stage destination index |
| wb_wen | input | 1 | WB instruction writes a register |
| wb_data | input | XLEN | Final write-back value |
| ex_fwd_a | output | XLEN | Selected first EX operand |
| ex_fwd_b | output | XLEN | Selected second EX operand |
| id_data_a | output | XLEN | Bypassed ID read data, first port |
| id_data_b | output | XLEN | Bypassed ID read data, second port |
| stall_o | output | 1 | Hold PC and IF/ID this cycle |
| bubble_o | output | 1 | Load a nop into ID/EX this cycle |

## Verification
The bound checker tests, on every cycle, the per-cycle relations between indices and data:
- MEM and WB forwarding, and MEM priority over WB.
- Suppression of a MEM-stage load.
- The index-0 exclusions.
- The ID bypass.
- Stall and bubble agreeing.
- A stall never lasting into a second cycle.

Only the bench's scenarios can show the timing of the interlock as a sequence: a stall, then a held-low cycle with the hazard still present, then a fresh stall. They also show the handoff, where the loaded value arrives through the WB path once the bubble has gone through, and the reset state.

// File: rtl/opb_pkg.sv
package opb_pkg;
    localparam int OPND_CNT = 2;

    typedef enum logic [1:0] {
        SRC_STAGE = 2'd0,
        SRC_MEM   = 2'd1,
        SRC_WB    = 2'd2
    } opb_src_e;

    typedef enum logic {
        LU_RUN  = 1'b0,
        LU_HOLD = 1'b1
    } lu_state_e;
endpackage

// File: rtl/opb_src_mux.sv
// Chooses one EX operand among the ID/EX value, MEM ALU result and WB value.
module opb_src_mux
    import opb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]   src_idx,
    input  logic [XLEN-1:0] stage_val,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_wen,
    input  logic            mem_is_load,
    input  logic [XLEN-1:0] mem_val,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_val,
    output opb_src_e        sel,
    output logic [XLEN-1:0] operand
);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        src_live = (src_idx != ZERO_IDX);
        // A load in MEM has no data yet; the interlock covers that case.
        mem_hit  = src_live && mem_wen && !mem_is_load && (mem_rd == src_idx);
        wb_hit   = src_live && wb_wen && (wb_rd == src_idx);
    end

    always_comb begin
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_STAGE;
        end
    end

    always_comb begin
        unique case (sel)
            SRC_MEM:   operand = mem_val;
            SRC_WB:    operand = wb_val;
            default:   operand = stage_val;
        endcase
    end
endmodule

// File: rtl/opb_rf_bypass.sv
// Replaces a register-file read with the value WB writes in the same cycle.
module opb_rf_bypass #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]   rd_idx,
    input  logic [XLEN-1:0] rf_val,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] rd_val
);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic wr_hit;

    always_comb begin
        wr_hit = wb_wen && (wb_rd != ZERO_IDX) && (wb_rd == rd_idx);
        rd_val = wr_hit ? wb_val : rf_val;
    end
endmodule

// File: rtl/opb_load_use.sv
// Load-use interlock: one-cycle hold guarded by a two-state machine.
module opb_load_use
    import opb_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_src [OPND_CNT],
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic          stall,
    output logic          bubble
);
    localparam logic [AW-1:0] ZERO_IDX = '0;

    lu_state_e state_q;
    lu_state_e state_nx;
    logic      src_match;
    logic      hazard;

    always_comb begin
        src_match = 1'b0;
        for (int i = 0; i < OPND_CNT; i++) begin
            if (id_src[i] == ex_rd) begin
                src_match = 1'b1;
            end
        end
        hazard = ex_is_load && ex_wen && (ex_rd != ZERO_IDX) && src_match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LU_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state: RUN_TO_HOLD, RUN_STAY, HOLD_TO_RUN
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LU_RUN:  state_nx = hazard ? LU_HOLD : LU_RUN;
            LU_HOLD: state_nx = LU_RUN;
            default: state_nx = LU_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        stall  = 1'b0;
        bubble = 1'b0;
        unique case (state_q)
            LU_RUN: begin
                stall  = hazard;
                bubble = hazard;
            end
            LU_HOLD: begin
                stall  = 1'b0;
                bubble = 1'b0;
            end
            default: begin
                stall  = 1'b0;
                bubble = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/opbypass_unit.sv
module opbypass_unit
    import opb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   id_rs_a,
    input  logic [AW-1:0]   id_rs_b,
    input  logic [XLEN-1:0] id_rf_rd_a,
    input  logic [XLEN-1:0] id_rf_rd_b,
    input  logic [AW-1:0]   ex_rs_a,
    input  logic [AW-1:0]   ex_rs_b,
    input  logic [XLEN-1:0] ex_opnd_a,
    input  logic [XLEN-1:0] ex_opnd_b,
    input  logic [AW-1:0]   ex_rd,
    input  logic            ex_wen,
    input  logic            ex_is_load,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_wen,
    input  logic            mem_is_load,
    input  logic [XLEN-1:0] mem_alu_res,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] ex_fwd_a,
    output logic [XLEN-1:0] ex_fwd_b,
    output logic [XLEN-1:0] id_data_a,
    output logic [XLEN-1:0] id_data_b,
    output logic            stall_o,
    output logic            bubble_o
);
    logic [AW-1:0]   id_src   [OPND_CNT];
    logic [XLEN-1:0] rf_raw   [OPND_CNT];
    logic [XLEN-1:0] id_out   [OPND_CNT];
    logic [AW-1:0]   ex_src   [OPND_CNT];
    logic [XLEN-1:0] ex_stage [OPND_CNT];
    logic [XLEN-1:0] ex_out   [OPND_CNT];
    opb_src_e        ex_sel   [OPND_CNT];

    assign id_src[0]   = id_rs_a;
    assign id_src[1]   = id_rs_b;
    assign rf_raw[0]   = id_rf_rd_a;
    assign rf_raw[1]   = id_rf_rd_b;
    assign ex_src[0]   = ex_rs_a;
    assign ex_src[1]   = ex_rs_b;
    assign ex_stage[0] = ex_opnd_a;
    assign ex_stage[1] = ex_opnd_b;

    generate
        for (genvar g = 0; g < OPND_CNT; g++) begin : g_opnd
            opb_src_mux #(.XLEN(XLEN), .AW(AW)) mux_i (
                .src_idx     (ex_src[g]),
                .stage_val   (ex_stage[g]),
                .mem_rd      (mem_rd),
                .mem_wen     (mem_wen),
                .mem_is_load (mem_is_load),
                .mem_val     (mem_alu_res),
                .wb_rd       (wb_rd),
                .wb_wen      (wb_wen),
                .wb_val      (wb_data),
                .sel         (ex_sel[g]),
                .operand     (ex_out[g])
            );

            opb_rf_bypass #(.XLEN(XLEN), .AW(AW)) byp_i (
                .rd_idx (id_src[g]),
                .rf_val (rf_raw[g]),
                .wb_rd  (wb_rd),
                .wb_wen (wb_wen),
                .wb_val (wb_data),
                .rd_val (id_out[g])
            );
        end
    endgenerate

    opb_load_use #(.AW(AW)) lu_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_src     (id_src),
        .ex_rd      (ex_rd),
        .ex_wen     (ex_wen),
        .ex_is_load (ex_is_load),
        .stall      (stall_o),
        .bubble     (bubble_o)
    );

    assign ex_fwd_a  = ex_out[0];
    assign ex_fwd_b  = ex_out[1];
    assign id_data_a = id_out[0];
    assign id_data_b = id_out[1];
endmodule

// File: rtl/opbypass_unit_chk.sv
module opbypass_unit_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   id_rs_a,
    input logic [XLEN-1:0] id_rf_rd_a,
    input logic [AW-1:0]   ex_rs_a,
    input logic [AW-1:0]   ex_rs_b,
    input logic [XLEN-1:0] ex_opnd_a,
    input logic [AW-1:0]   ex_rd,
    input logic            ex_wen,
    input logic            ex_is_load,
    input logic [AW-1:0]   mem_rd,
    input logic            mem_wen,
    input logic            mem_is_load,
    input logic [XLEN-1:0] mem_alu_res,
    input logic [AW-1:0]   wb_rd,
    input logic            wb_wen,
    input logic [XLEN-1:0] wb_data,
    input logic [XLEN-1:0] ex_fwd_a,
    input logic [XLEN-1:0] ex_fwd_b,
    input logic [XLEN-1:0] id_data_a,
    input logic            stall_o,
    input logic            bubble_o
);
    localparam logic [AW-1:0] Z = '0;

    // R1 R3
    mem_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && !mem_is_load && mem_rd != Z && mem_rd == ex_rs_a) |-> ex_fwd_a == mem_alu_res);

    // R1
    mem_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && !mem_is_load && mem_rd != Z && mem_rd == ex_rs_b) |-> ex_fwd_b == mem_alu_res);

    // R2
    wb_fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wen && wb_rd != Z && wb_rd == ex_rs_a
         && !(mem_wen && !mem_is_load && mem_rd == ex_rs_a)) |-> ex_fwd_a == wb_data);

    // R4
    load_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_is_load && mem_rd == ex_rs_a && !(wb_wen && wb_rd == ex_rs_a && wb_rd != Z))
        |-> ex_fwd_a == ex_opnd_a);

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs_a == Z) |-> ex_fwd_a == ex_opnd_a);

    // R5
    zero_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs_a == Z) |-> id_data_a == id_rf_rd_a);

    // R5
    zero_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == Z) |-> !stall_o);

    // R6
    rf_byp_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wen && wb_rd != Z && wb_rd == id_rs_a) |-> id_data_a == wb_data);

    // R9
    no_wen_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_wen && ex_is_load) |-> !stall_o);

    // R7
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> bubble_o);

    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);
endmodule

bind opbypass_unit opbypass_unit_chk #(.XLEN(XLEN), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs_a     (id_rs_a),
    .id_rf_rd_a  (id_rf_rd_a),
    .ex_rs_a     (ex_rs_a),
    .ex_rs_b     (ex_rs_b),
    .ex_opnd_a   (ex_opnd_a),
    .ex_rd       (ex_rd),
    .ex_wen      (ex_wen),
    .ex_is_load  (ex_is_load),
    .mem_rd      (mem_rd),
    .mem_wen     (mem_wen),
    .mem_is_load (mem_is_load),
    .mem_alu_res (mem_alu_res),
    .wb_rd       (wb_rd),
    .wb_wen      (wb_wen),
    .wb_data     (wb_data),
    .ex_fwd_a    (ex_fwd_a),
    .ex_fwd_b    (ex_fwd_b),
    .id_data_a   (id_data_a),
    .stall_o     (stall_o),
    .bubble_o    (bubble_o)
);

// File: tb/opbypass_unit_tb_top.sv
`timescale 1ns/1ps
module opbypass_unit_tb_top;
    localparam int XLEN = 32;
    localparam int AW   = 5;

    localparam logic [XLEN-1:0] V_STAGE_A = 32'hA0A0_0001;
    localparam logic [XLEN-1:0] V_STAGE_B = 32'hB0B0_0002;
    localparam logic [XLEN-1:0] V_MEM     = 32'h1111_1111;
    localparam logic [XLEN-1:0] V_WB      = 32'h2222_2222;
    localparam logic [XLEN-1:0] V_RF_A    = 32'h3333_0003;
    localparam logic [XLEN-1:0] V_RF_B    = 32'h3333_0004;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd;
    logic [XLEN-1:0] id_rf_rd_a, id_rf_rd_b, ex_opnd_a, ex_opnd_b, mem_alu_res, wb_data;
    logic            ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
    logic [XLEN-1:0] ex_fwd_a, ex_fwd_b, id_data_a, id_data_b;
    logic            stall_o, bubble_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    opbypass_unit #(.XLEN(XLEN), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .id_rf_rd_a(id_rf_rd_a), .id_rf_rd_b(id_rf_rd_b),
        .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b),
        .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
        .mem_alu_res(mem_alu_res),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_data(wb_data),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
        .id_data_a(id_data_a), .id_data_b(id_data_b),
        .stall_o(stall_o), .bubble_o(bubble_o)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic zero_inputs();
        id_rs_a = '0; id_rs_b = '0; id_rf_rd_a = '0; id_rf_rd_b = '0;
        ex_rs_a = '0; ex_rs_b = '0; ex_opnd_a = '0; ex_opnd_b = '0;
        ex_rd = '0; ex_wen = 1'b0; ex_is_load = 1'b0;
        mem_rd = '0; mem_wen = 1'b0; mem_is_load = 1'b0; mem_alu_res = '0;
        wb_rd = '0; wb_wen = 1'b0; wb_data = '0;
    endtask

    // Neutral data values with no index match anywhere.
    task automatic base_inputs();
        zero_inputs();
        id_rf_rd_a = V_RF_A; id_rf_rd_b = V_RF_B;
        ex_opnd_a = V_STAGE_A; ex_opnd_b = V_STAGE_B;
        mem_alu_res = V_MEM; wb_data = V_WB;
        ex_rd = 5'd30; mem_rd = 5'd29; wb_rd = 5'd28;
        id_rs_a = 5'd1; id_rs_b = 5'd2; ex_rs_a = 5'd3; ex_rs_b = 5'd4;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        zero_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();
        chk("R10 stall after reset", {31'b0, stall_o}, '0);
        chk("R10 bubble after reset", {31'b0, bubble_o}, '0);
        chk("R10 ex_fwd_a after reset", ex_fwd_a, '0);
        chk("R10 id_data_b after reset", id_data_b, '0);
    endtask

    task automatic t_mem_fwd();
        base_inputs();
        mem_wen = 1'b1; mem_rd = 5'd3;
        #2;
        chk("R1 mem to ex operand a", ex_fwd_a, V_MEM);
        chk("R1 operand b untouched", ex_fwd_b, V_STAGE_B);
        ex_rs_b = 5'd3;
        #2;
        chk("R1 mem to ex operand b", ex_fwd_b, V_MEM);
    endtask

    task automatic t_wb_fwd();
        base_inputs();
        wb_wen = 1'b1; wb_rd = 5'd4;
        #2;
        chk("R2 wb to ex operand b", ex_fwd_b, V_WB);
        chk("R2 operand a untouched", ex_fwd_a, V_STAGE_A);
    endtask

    task automatic t_priority();
        base_inputs();
        mem_wen = 1'b1; mem_rd = 5'd3;
        wb_wen = 1'b1; wb_rd = 5'd3;
        #2;
        chk("R3 mem wins over wb", ex_fwd_a, V_MEM);
    endtask

    task automatic t_load_no_fwd();
        base_inputs();
        mem_wen = 1'b1; mem_is_load = 1'b1; mem_rd = 5'd3;
        #2;
        chk("R4 mem load not forwarded", ex_fwd_a, V_STAGE_A);
        wb_wen = 1'b1; wb_rd = 5'd3;
        #2;
        chk("R4 mem load falls to wb", ex_fwd_a, V_WB);
    endtask

    task automatic t_zero_reg();
        base_inputs();
        ex_rs_a = '0; mem_rd = '0; mem_wen = 1'b1;
        wb_rd = '0; wb_wen = 1'b1; id_rs_b = '0;
        ex_rd = '0; ex_wen = 1'b1; ex_is_load = 1'b1; id_rs_a = '0;
        #2;
        chk("R5 r0 not forwarded in ex", ex_fwd_a, V_STAGE_A);
        chk("R5 r0 not bypassed in id", id_data_b, V_RF_B);
        chk("R5 r0 load no stall", {31'b0, stall_o}, '0);
    endtask

    task automatic t_rf_bypass();
        base_inputs();
        wb_wen = 1'b1; wb_rd = 5'd2;
        #2;
        chk("R6 id port b bypassed", id_data_b, V_WB);
        chk("R6 id port a raw", id_data_a, V_RF_A);
    endtask

    task automatic t_no_wen();
        base_inputs();
        mem_rd = 5'd3; wb_rd = 5'd1;
        ex_rd = 5'd2; ex_is_load = 1'b1;
        #2;
        chk("R9 mem no wen no fwd", ex_fwd_a, V_STAGE_A);
        chk("R9 wb no wen no bypass", id_data_a, V_RF_A);
        chk("R9 load no wen no stall", {31'b0, stall_o}, '0);
    endtask

    task automatic t_load_use();
        settle();
        base_inputs();
        ex_rd = 5'd2; ex_wen = 1'b1; ex_is_load = 1'b1;
        #2;
        chk("R7 stall on load-use", {31'b0, stall_o}, 32'd1);
        chk("R7 bubble on load-use", {31'b0, bubble_o}, 32'd1);
        settle();
        chk("R8 hold state keeps stall low", {31'b0, stall_o}, '0);
        chk("R8 hold state keeps bubble low", {31'b0, bubble_o}, '0);
        settle();
        chk("R8 back to run stalls again", {31'b0, stall_o}, 32'd1);
        // Load moves on, bubble in EX; next cycle the load result is in WB.
        settle();
        base_inputs();
        ex_rs_b = 5'd2; wb_wen = 1'b1; wb_rd = 5'd2;
        #2;
        chk("R8 no stall after bubble", {31'b0, stall_o}, '0);
        chk("R8 loaded value via wb path", ex_fwd_b, V_WB);
        settle();
        base_inputs();
        ex_rd = 5'd1; ex_wen = 1'b1; ex_is_load = 1'b1;
        #2;
        chk("R7 stall on port a source", {31'b0, stall_o}, 32'd1);
        settle();
        base_inputs();
        settle();
    endtask

    initial begin
        zero_inputs();
        rst_n = 1'b0;
        t_reset();
        settle(); t_mem_fwd();
        settle(); t_wb_fwd();
        settle(); t_priority();
        settle(); t_load_no_fwd();
        settle(); t_zero_reg();
        settle(); t_rf_bypass();
        settle(); t_no_wen();
        t_load_use();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule